// File: doc/BRIEF.md
# Priority-Label Mailbox Capture Unit

This unit sits beside a serial-data word receiver and pulls selected words aside into three dedicated mailboxes. Software programs three 8-bit label match values through a byte-serial command port. Each received 32-bit word carries its label in bits 7:0. When capture is enabled and that label equals a match value, the upper 24 bits of the word are stored in the mailbox that belongs to the match value, and that mailbox's data-available flag rises. The label itself is not stored, because the match value already implies it.

Commands arrive as bytes. A byte marked as first is an opcode. The load opcode is followed by three data bytes, which fill the match values from the last one down. Other opcodes return the match values or the contents of one mailbox on a 24-bit read port one cycle later. Reading a mailbox clears its flag, unless a new word is captured into it in the same cycle. A parameter selects the opcode set for the first or the second receiver instance.

Top module: `plmb_capture`

## Requirements
- R1: While reset is active and after it is released, every match value is 0x00, all three flags are 0, rd_vld is 0 and rd_data is 0.
- R2: After the load opcode (0x18 for unit 0, 0x2C for unit 1), the next three non-opcode bytes are written to match value #3, then #2, then #1.
- R3: The read-back opcode (0x9C for unit 0, 0xBC for unit 1) makes rd_vld high for exactly one cycle, in the cycle after the opcode byte is taken. rd_data then holds #3 in bits 23:16, #2 in bits 15:8 and #1 in bits 7:0.
- R4: When rx_vld and cap_en are both 1 and rx_word[7:0] equals match value #k, mailbox #k stores rx_word[31:8] and mb_flag[k-1] is 1 from the next cycle on.
- R5: When cap_en is 0, a received word changes no mailbox and no flag.
- R6: When one label is held in several match values, every matching mailbox captures the word in the same cycle.
- R7: Mailbox opcodes 0xA4, 0xA8 and 0xAC (unit 0) or 0xC4, 0xC8 and 0xCC (unit 1) select mailbox #1, #2 and #3. The 24-bit contents appear on rd_data with a one-cycle rd_vld pulse, and the mailbox's flag clears.
- R8: A capture into a mailbox in the same cycle as its read leaves the flag set. The read returns the older contents, and the new word is kept for the next read.
- R9: A word whose label matches no match value changes no mailbox and no flag.
- R10: An unknown opcode and data bytes outside a load sequence produce no rd_vld and change no match value. A new opcode during a load ends that load and keeps the values already written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command byte strobe |
| cmd_first | input | 1 | Marks the strobed byte as an opcode |
| cmd_byte | input | 8 | Command or data byte |
| rx_vld | input | 1 | Received word strobe |
| rx_word | input | 32 | Received word, label in bits 7:0 |
| cap_en | input | 1 | Capture enable |
| mb_flag | output | 3 | Per-mailbox data-available flags, bit 0 for #1 |
| rd_vld | output | 1 | Read data valid pulse |
| rd_data | output | 24 | Read data |

## Verification
The bench loads distinct match values and reads them back, so it can tell whether the load order is reversed. It sends words whose labels hit one slot, then another, then none, so it can tell whether a capture lands in the wrong mailbox. It loads a duplicated label to show that both matching mailboxes capture together. It also issues a read and a capture to the same mailbox in one cycle, which separates "capture wins" from "read clears". Words sent with capture disabled, stray bytes, unknown opcodes and a load cut short by a new opcode show which stimuli must leave the state untouched.

// File: rtl/plmb_pkg.sv
package plmb_pkg;
  localparam int LBL_W  = 8;
  localparam int WORD_W = 32;
  localparam int NSLOT  = 3;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_MATCH = 2'd1,
    RD_MBOX  = 2'd2
  } rd_kind_e;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_LOAD = 1'b1
  } cmd_state_e;
endpackage

// File: rtl/plmb_cmd_dec.sv
module plmb_cmd_dec
  import plmb_pkg::*;
#(
  parameter int          NSLOT_P    = 3,
  parameter int          BYTE_W     = 8,
  parameter logic [7:0]  OP_LOAD    = 8'h18,
  parameter logic [7:0]  OP_RDM     = 8'h9C,
  parameter logic [7:0]  OP_MB_BASE = 8'hA4,
  parameter int          OP_MB_STEP = 4,
  localparam int         SLOT_W     = (NSLOT_P > 1) ? $clog2(NSLOT_P) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_vld,
  input  logic               cmd_first,
  input  logic [BYTE_W-1:0]  cmd_byte,
  output logic [NSLOT_P-1:0] mw_en,
  output logic [BYTE_W-1:0]  mw_byte,
  output rd_kind_e           rd_kind,
  output logic [SLOT_W-1:0]  rd_slot,
  output logic [NSLOT_P-1:0] mb_clr
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLOT_P - 1);

  cmd_state_e        state_q, state_d;
  logic [SLOT_W-1:0] idx_q, idx_d;

  assign mw_byte = cmd_byte;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    mw_en   = '0;
    rd_kind = RD_NONE;
    rd_slot = '0;
    mb_clr  = '0;
    if (cmd_vld) begin
      if (cmd_first) begin
        state_d = CS_IDLE;
        idx_d   = '0;
        if (cmd_byte == OP_LOAD) begin
          state_d = CS_LOAD;
        end else if (cmd_byte == OP_RDM) begin
          rd_kind = RD_MATCH;
        end else begin
          for (int k = 0; k < NSLOT_P; k++) begin
            if (cmd_byte == BYTE_W'(int'(OP_MB_BASE) + k * OP_MB_STEP)) begin
              rd_kind   = RD_MBOX;
              rd_slot   = k[SLOT_W-1:0];
              mb_clr[k] = 1'b1;
            end
          end
        end
      end else if (state_q == CS_LOAD) begin
        mw_en[NSLOT_P - 1 - int'(idx_q)] = 1'b1;
        if (idx_q == LAST) begin
          state_d = CS_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // R2: a load sequence never walks past the last slot
  p_load_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_LOAD) |-> (idx_q <= LAST));

  // R10: a data byte with no load in progress writes nothing
  p_stray_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_first && state_q == CS_IDLE) |-> (mw_en == '0));
endmodule

// File: rtl/plmb_match_bank.sv
module plmb_match_bank #(
  parameter int NSLOT_P = 3,
  parameter int LBL_W_P = 8,
  parameter int WORD_P  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSLOT_P-1:0]         wr_en,
  input  logic [LBL_W_P-1:0]         wr_byte,
  input  logic                       rx_vld,
  input  logic                       cap_en,
  input  logic [WORD_P-1:0]          rx_word,
  output logic [NSLOT_P*LBL_W_P-1:0] match_flat,
  output logic [NSLOT_P-1:0]         hit
);
  logic [LBL_W_P-1:0] rx_lbl;
  logic               cap_go;

  assign rx_lbl = rx_word[LBL_W_P-1:0];
  assign cap_go = rx_vld & cap_en;

  for (genvar i = 0; i < NSLOT_P; i++) begin : g_slot
    logic [LBL_W_P-1:0] m_q, m_d;

    always_comb begin
      m_d = m_q;
      if (wr_en[i]) m_d = wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= '0;
      else        m_q <= m_d;
    end

    assign match_flat[i*LBL_W_P +: LBL_W_P] = m_q;
    assign hit[i] = cap_go & (rx_lbl == m_q);
  end

  // R10: without a write strobe from the decoder, every match value holds
  p_match_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(match_flat));
endmodule

// File: rtl/plmb_mbox_slot.sv
module plmb_mbox_slot #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_q
);
  logic [DATA_W-1:0] data_d;
  logic              flag_d;

  always_comb begin
    data_d = data_q;
    flag_d = flag_q;
    if (rd_clr) flag_d = 1'b0;
    if (cap) begin
      data_d = cap_data;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      data_q <= data_d;
      flag_q <= flag_d;
    end
  end

  // R4 / R8: a capture always leaves the flag set, even during a read
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> flag_q);

  // R7: a read with no capture clears the flag
  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !cap) |=> !flag_q);

  // R9: contents change only on a capture
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(data_q));
endmodule

// File: rtl/plmb_rd_mux.sv
module plmb_rd_mux
  import plmb_pkg::*;
#(
  parameter int NSLOT_P = 3,
  parameter int LBL_W_P = 8,
  parameter int DATA_W  = 24,
  localparam int SLOT_W = (NSLOT_P > 1) ? $clog2(NSLOT_P) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  rd_kind_e                   rd_kind,
  input  logic [SLOT_W-1:0]          rd_slot,
  input  logic [NSLOT_P*LBL_W_P-1:0] match_flat,
  input  logic [NSLOT_P*DATA_W-1:0]  mb_flat,
  output logic                       rd_vld,
  output logic [DATA_W-1:0]          rd_data
);
  logic              vld_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    vld_d  = 1'b0;
    data_d = rd_data;
    case (rd_kind)
      RD_MATCH: begin
        vld_d  = 1'b1;
        data_d = '0;
        for (int i = 0; i < NSLOT_P; i++) begin
          data_d[i*LBL_W_P +: LBL_W_P] = match_flat[i*LBL_W_P +: LBL_W_P];
        end
      end
      RD_MBOX: begin
        vld_d  = 1'b1;
        data_d = mb_flat[int'(rd_slot)*DATA_W +: DATA_W];
      end
      default: begin
        vld_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld  <= vld_d;
      rd_data <= data_d;
    end
  end
endmodule

// File: rtl/plmb_capture.sv
module plmb_capture
  import plmb_pkg::*;
#(
  parameter int RX_UNIT = 0,
  localparam int DATA_W = WORD_W - LBL_W,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic              cmd_first,
  input  logic [LBL_W-1:0]  cmd_byte,
  input  logic              rx_vld,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              cap_en,
  output logic [NSLOT-1:0]  mb_flag,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [7:0] OP_LOAD    = (RX_UNIT == 0) ? 8'h18 : 8'h2C;
  localparam logic [7:0] OP_RDM     = (RX_UNIT == 0) ? 8'h9C : 8'hBC;
  localparam logic [7:0] OP_MB_BASE = (RX_UNIT == 0) ? 8'hA4 : 8'hC4;
  localparam int         OP_MB_STEP = 4;

  logic [NSLOT-1:0]        mw_en;
  logic [LBL_W-1:0]        mw_byte;
  rd_kind_e                rd_kind;
  logic [SLOT_W-1:0]       rd_slot;
  logic [NSLOT-1:0]        mb_clr;
  logic [NSLOT*LBL_W-1:0]  match_flat;
  logic [NSLOT-1:0]        hit;
  logic [NSLOT*DATA_W-1:0] mb_flat;

  plmb_cmd_dec #(
    .NSLOT_P(NSLOT), .BYTE_W(LBL_W), .OP_LOAD(OP_LOAD), .OP_RDM(OP_RDM),
    .OP_MB_BASE(OP_MB_BASE), .OP_MB_STEP(OP_MB_STEP)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_first(cmd_first),
    .cmd_byte(cmd_byte), .mw_en(mw_en), .mw_byte(mw_byte),
    .rd_kind(rd_kind), .rd_slot(rd_slot), .mb_clr(mb_clr)
  );

  plmb_match_bank #(.NSLOT_P(NSLOT), .LBL_W_P(LBL_W), .WORD_P(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(mw_en), .wr_byte(mw_byte),
    .rx_vld(rx_vld), .cap_en(cap_en), .rx_word(rx_word),
    .match_flat(match_flat), .hit(hit)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_mbox
    plmb_mbox_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .cap(hit[i]),
      .cap_data(rx_word[WORD_W-1:LBL_W]), .rd_clr(mb_clr[i]),
      .data_q(mb_flat[i*DATA_W +: DATA_W]), .flag_q(mb_flag[i])
    );
  end

  plmb_rd_mux #(.NSLOT_P(NSLOT), .LBL_W_P(LBL_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_kind(rd_kind), .rd_slot(rd_slot),
    .match_flat(match_flat), .mb_flat(mb_flat),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  // R3: a read-back opcode yields a valid pulse on the next cycle
  p_rd_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_first && cmd_byte == OP_RDM) |=> rd_vld);

  // R10: no opcode, no read pulse
  p_no_spur_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld && cmd_first) |=> !rd_vld);

  // R5: capture disabled leaves every mailbox untouched
  p_cap_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(mb_flat));

  // R4: a flag only rises after a strobed, enabled word
  p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_flag != $past(mb_flag) && (mb_flag & ~$past(mb_flag)) != '0)
      |-> $past(rx_vld && cap_en));
endmodule

// File: tb/plmb_capture_test.sv
module plmb_capture_test;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_vld, cmd_first;
  logic [7:0]  cmd_byte;
  logic        rx_vld;
  logic [31:0] rx_word;
  logic        cap_en;
  logic [2:0]  mb_flag;
  logic        rd_vld;
  logic [23:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  plmb_capture #(.RX_UNIT(0)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_first(cmd_first),
    .cmd_byte(cmd_byte), .rx_vld(rx_vld), .rx_word(rx_word), .cap_en(cap_en),
    .mb_flag(mb_flag), .rd_vld(rd_vld), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data shows up
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rd_vld === 1'b1) begin
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R10 actual=rd_vld %h expected=no read", rd_data);
      end else begin
        automatic logic [23:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        check(t, {8'h0, rd_data}, {8'h0, e});
      end
    end
  end

  task automatic put_byte(input logic first, input logic [7:0] b);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_first = first; cmd_byte = b;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_first = 1'b0;
  endtask

  task automatic load(input logic [7:0] m3, input logic [7:0] m2, input logic [7:0] m1);
    put_byte(1'b1, 8'h18);
    put_byte(1'b0, m3);
    put_byte(1'b0, m2);
    put_byte(1'b0, m1);
  endtask

  task automatic rd_match(input logic [23:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    put_byte(1'b1, 8'h9C);
  endtask

  task automatic rd_mb(input int k, input logic [23:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    put_byte(1'b1, 8'hA4 + 8'(4 * (k - 1)));
  endtask

  task automatic send_word(input logic [23:0] d, input logic [7:0] lbl);
    @(negedge clk);
    rx_vld = 1'b1; rx_word = {d, lbl};
    @(negedge clk);
    rx_vld = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_first = 1'b0; cmd_byte = '0;
    rx_vld = 1'b0; rx_word = '0; cap_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 flags in reset", {29'h0, mb_flag}, 32'h0);
    check("R1 rd_vld in reset", {31'h0, rd_vld}, 32'h0);
    check("R1 rd_data in reset", {8'h0, rd_data}, 32'h0);
    rst_n = 1'b1;
    rd_match(24'h000000, "R1 match values after reset");

    load(8'h33, 8'h22, 8'h11);
    rd_match(24'h332211, "R2 R3 load order and read-back");
    put_byte(1'b0, 8'h77);
    rd_match(24'h332211, "R10 stray byte ignored");
    put_byte(1'b1, 8'h55);
    check("R10 unknown opcode no read", {31'h0, rd_vld}, 32'h0);

    cap_en = 1'b1;
    send_word(24'hABCDEF, 8'h11);
    check("R4 capture into #1", {29'h0, mb_flag}, 32'h1);
    send_word(24'h123456, 8'h33);
    check("R4 capture into #3", {29'h0, mb_flag}, 32'h5);
    rd_mb(1, 24'hABCDEF, "R7 read mailbox #1");
    check("R7 flag #1 cleared", {29'h0, mb_flag}, 32'h4);
    rd_mb(3, 24'h123456, "R7 read mailbox #3");
    check("R7 flag #3 cleared", {29'h0, mb_flag}, 32'h0);

    send_word(24'h444444, 8'h44);
    check("R9 non-matching label", {29'h0, mb_flag}, 32'h0);
    rd_mb(2, 24'h000000, "R9 mailbox #2 untouched");

    cap_en = 1'b0;
    send_word(24'h999999, 8'h11);
    check("R5 capture disabled flags", {29'h0, mb_flag}, 32'h0);
    rd_mb(1, 24'hABCDEF, "R5 capture disabled contents");
    cap_en = 1'b1;

    load(8'h5A, 8'h22, 8'h5A);
    rd_match(24'h5A225A, "R2 reload");
    send_word(24'h0F0F0F, 8'h5A);
    check("R6 duplicate label flags", {29'h0, mb_flag}, 32'h5);
    rd_mb(1, 24'h0F0F0F, "R6 mailbox #1");
    rd_mb(3, 24'h0F0F0F, "R6 mailbox #3");

    send_word(24'h111111, 8'h5A);
    check("R4 recapture flags", {29'h0, mb_flag}, 32'h5);
    exp_q.push_back(24'h111111); tag_q.push_back("R8 read returns older word");
    @(negedge clk);
    cmd_vld = 1'b1; cmd_first = 1'b1; cmd_byte = 8'hA4;
    rx_vld = 1'b1; rx_word = {24'h222222, 8'h5A};
    @(negedge clk);
    cmd_vld = 1'b0; cmd_first = 1'b0; rx_vld = 1'b0;
    check("R8 flag kept on read+capture", {29'h0, mb_flag}, 32'h5);
    rd_mb(1, 24'h222222, "R8 new word kept");
    check("R7 flag #1 cleared after second read", {29'h0, mb_flag}, 32'h4);

    put_byte(1'b1, 8'h18);
    put_byte(1'b0, 8'hC1);
    exp_q.push_back(24'hC1225A); tag_q.push_back("R10 aborted load");
    put_byte(1'b1, 8'h9C);
    put_byte(1'b0, 8'h99);
    rd_match(24'hC1225A, "R10 byte after abort ignored");

    repeat (4) @(negedge clk);
    check("R3 all reads answered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule